// File: doc/BRIEF.md
# Dual-View Product Register Block

This block is a small memory-mapped register file on a 16-bit address and 16-bit data bus. It keeps a one-bit view selector in a configuration register and a 32-bit operand word that software loads as two 16-bit halves at two separate addresses. The operand word always holds exactly what was last written to it, whatever the selector says.

The selector controls what is seen, not what is stored. In raw view (selector 0), reads of the two half addresses return the stored halves. In product view (selector 1), they return the low and high halves of the unsigned 32-bit product of the two stored halves.

The same selected 32-bit word is also driven continuously to the surrounding hardware. Read data is registered, so it appears one cycle after the read strobe and is qualified by a valid flag.

Top module: `dual_view_regs`

## Requirements
- R1: After reset the selector is 0 (raw view) and both stored halves are zero, so `hw_value_o` is 0 and every mapped read returns 0.
- R2: A write to 0xA002 loads stored bits [15:0] and a write to 0xA004 loads stored bits [31:16]. The stored word keeps the last written values across any number of selector changes.
- R3: The product is unsigned and 32 bits wide and never overflows. 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R4: With selector 0, a read of 0xA002 returns stored [15:0] and a read of 0xA004 returns stored [31:16].
- R5: With selector 1, a read of 0xA002 returns product [15:0] and a read of 0xA004 returns product [31:16].
- R6: `hw_value_o` is the stored word {hi,lo} when the selector is 0 and the product when it is 1.
- R7: The configuration register is at 0xA000. A write stores only data bit 0 as the selector. A read returns the selector in bit 0 and zeros in bits [15:1].
- R8: A read strobe in one cycle gives `rvalid_o` high with the data in the next cycle. `rvalid_o` is low in a cycle that follows no read strobe.
- R9: Reads of any address other than 0xA000, 0xA002 and 0xA004 return 0. Writes to such addresses change neither the stored word nor the selector.
- R10: A read issued in the cycle right after a selector write already reflects the new selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `re_i` |
| hw_value_o | output | 32 | Selected 32-bit word for the surrounding hardware |

## Verification
The assertions assume that `we_i` and `re_i` are never high in the same cycle. A read in the same cycle as a write would return the pre-write view, and the read-back properties are not written for that overlap. The stimulus therefore issues each access as its own single-cycle strobe, with each strobe released before the next is raised. It also keeps addresses stable for the whole strobe cycle, so the decode the properties rely on sees one address per access.

// File: rtl/dvr_pkg.sv
package dvr_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_MULT   = 1'b1
  } mode_e;
endpackage

// File: rtl/dvr_store.sv
module dvr_store
  import dvr_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter int unsigned          DATA_W   = 16,
  parameter logic [ADDR_W-1:0]    CFG_ADDR = 16'hA000,
  parameter logic [ADDR_W-1:0]    LO_ADDR  = 16'hA002,
  parameter logic [ADDR_W-1:0]    HI_ADDR  = 16'hA004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output mode_e             mode_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  mode_e             mode_q;
  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DIRECT;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        CFG_ADDR: mode_q <= mode_e'(wdata_i[0]);
        LO_ADDR:  lo_q   <= wdata_i;
        HI_ADDR:  hi_q   <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;

  a_r2_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == LO_ADDR) |=> lo_q == $past(wdata_i));
  a_r2_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == HI_ADDR) |=> hi_q == $past(wdata_i));
  a_r9_lo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == LO_ADDR) |=> $stable(lo_q));
  a_r9_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == HI_ADDR) |=> $stable(hi_q));
  a_r7_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CFG_ADDR) |=> $stable(mode_q));
endmodule

// File: rtl/dvr_mult.sv
module dvr_mult #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  // unsigned, full width: cannot overflow
  always_comb prod_o = PROD_W'(a_i) * PROD_W'(b_i);
endmodule

// File: rtl/dvr_view.sv
module dvr_view
  import dvr_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter int unsigned          DATA_W   = 16,
  parameter logic [ADDR_W-1:0]    CFG_ADDR = 16'hA000,
  parameter logic [ADDR_W-1:0]    LO_ADDR  = 16'hA002,
  parameter logic [ADDR_W-1:0]    HI_ADDR  = 16'hA004,
  localparam int unsigned         PROD_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              re_i,
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [PROD_W-1:0] hw_value_o
);
  logic [PROD_W-1:0] view;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              mapped;

  always_comb view = (mode_i == MODE_MULT) ? prod_i : {hi_i, lo_i};
  assign hw_value_o = view;
  assign mapped = (addr_i == CFG_ADDR) || (addr_i == LO_ADDR) || (addr_i == HI_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) begin
        unique case (addr_i)
          CFG_ADDR: rdata_q <= {{(DATA_W-1){1'b0}}, mode_i == MODE_MULT};
          LO_ADDR:  rdata_q <= view[DATA_W-1:0];
          HI_ADDR:  rdata_q <= view[PROD_W-1:DATA_W];
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o);
  a_r8_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o);
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == '0);
  a_r7_cfg_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == CFG_ADDR) |=> rdata_o[DATA_W-1:1] == '0);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i != '0) |-> prod_i >= PROD_W'(lo_i));
  a_r5_zero_factor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MULT && (lo_i == '0 || hi_i == '0)) |-> hw_value_o == '0);
  a_r6_raw_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIRECT) |-> hw_value_o[DATA_W-1:0] == lo_i);
endmodule

// File: rtl/dual_view_regs.sv
module dual_view_regs
  import dvr_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hA000,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 16'hA002,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 16'hA004,
  localparam int unsigned      PROD_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [PROD_W-1:0] hw_value_o
);
  mode_e             mode;
  logic [DATA_W-1:0] lo, hi;
  logic [PROD_W-1:0] prod;

  dvr_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_ADDR(CFG_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .mode_o(mode), .lo_o(lo), .hi_o(hi)
  );

  dvr_mult #(.DATA_W(DATA_W)) u_mult (
    .a_i(lo), .b_i(hi), .prod_o(prod)
  );

  dvr_view #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_ADDR(CFG_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_view (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .re_i(re_i),
    .mode_i(mode), .lo_i(lo), .hi_i(hi), .prod_i(prod),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .hw_value_o(hw_value_o)
  );

  a_r1_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> hw_value_o == '0);
endmodule

// File: tb/dual_view_regs_tb.sv
module dual_view_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [15:0] rdata_o;
  logic        rvalid_o;
  logic [31:0] hw_value_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic        m_mode = 1'b0;
  logic [15:0] m_lo = '0;
  logic [15:0] m_hi = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  dual_view_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .hw_value_o(hw_value_o)
  );

  function automatic logic [31:0] model_view();
    logic [31:0] p;
    p = {16'h0, m_lo} * {16'h0, m_hi};
    return m_mode ? p : {m_hi, m_lo};
  endfunction

  function automatic logic [15:0] model_read(input logic [15:0] a);
    logic [31:0] v;
    v = model_view();
    case (a)
      16'hA000: return {15'h0, m_mode};
      16'hA002: return v[15:0];
      16'hA004: return v[31:16];
      default:  return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; re_i = 1'b0;
    @(negedge clk_i);
    we_i = 1'b0;
    case (a)
      16'hA000: m_mode = d[0];
      16'hA002: m_lo = d;
      16'hA004: m_hi = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0; re_i = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(req);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 valid idle", {31'h0, rvalid_o}, 32'h0);
  endtask

  // monitor: pops expected reads as they return
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected valid", 32'h1, 32'h0);
      end else begin
        logic [15:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {16'h0, rdata_o}, {16'h0, e});
      end
    end
  end

  initial begin
    #(20 * 100000);
    check("watchdog", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 hw_value after reset", hw_value_o, 32'h0);
    check("R1 valid after reset", {31'h0, rvalid_o}, 32'h0);
    rd(16'hA000, "R1 cfg reset");
    rd(16'hA002, "R1 lo reset");
    rd(16'hA004, "R1 hi reset");

    wr(16'hA002, 16'h1234);
    wr(16'hA004, 16'h0003);
    rd(16'hA002, "R4 raw lo");
    rd(16'hA004, "R4 raw hi");
    check("R6 hw raw", hw_value_o, 32'h0003_1234);
    idle_check();

    wr(16'hA000, 16'h0001);
    rd(16'hA002, "R10 lo right after mode write");
    rd(16'hA004, "R5 product hi");
    check("R6 hw product", hw_value_o, 32'h0000_369C);
    rd(16'hA000, "R7 cfg reads one");
    wr(16'hA000, 16'hFFFF);
    rd(16'hA000, "R7 only bit0 stored");

    wr(16'hA002, 16'hFFFF);
    wr(16'hA004, 16'hFFFF);
    rd(16'hA002, "R3 max product lo");
    rd(16'hA004, "R3 max product hi");
    check("R3 hw max product", hw_value_o, 32'hFFFE_0001);

    wr(16'hA000, 16'hFFFE);
    rd(16'hA002, "R2 storage kept lo");
    rd(16'hA004, "R2 storage kept hi");
    check("R2 hw raw after modes", hw_value_o, 32'hFFFF_FFFF);

    wr(16'hA006, 16'h5555);
    wr(16'hA003, 16'h5555);
    wr(16'h2002, 16'h5555);
    wr(16'h2000, 16'h0001);
    check("R9 hw unchanged", hw_value_o, 32'hFFFF_FFFF);
    rd(16'hA006, "R9 unmapped read zero");
    rd(16'h2002, "R9 alias read zero");
    rd(16'hA002, "R9 lo untouched");
    rd(16'hA004, "R9 hi untouched");
    rd(16'hA000, "R9 mode untouched");
    idle_check();

    lfsr = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr ^ 16'h5A5A;
      wr(16'hA002, a);
      wr(16'hA004, b);
      wr(16'hA000, {15'h0, i[0]});
      rd(16'hA002, i[0] ? "R5 sweep lo" : "R4 sweep lo");
      rd(16'hA004, i[0] ? "R5 sweep hi" : "R4 sweep hi");
      @(negedge clk_i);
      check("R6 sweep hw", hw_value_o, model_view());
    end

    repeat (3) @(negedge clk_i);
    check("R8 queue drained", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule